// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Software Acknowledge

This block receives asynchronous serial frames on a single input line and places each data byte in a receive buffer that software reads. An external bit-clock enable pulses a fixed number of times per bit period. The receiver waits for a falling edge on the synchronized line and confirms the start bit at its middle. It then samples each data bit, an optional parity bit and the stop bit at the middle of its bit period.

Software controls the receiver through a small set of register-style inputs: a level enable, an acknowledge strobe pulsed after the buffer has been read, a parity enable, a parity sense select, and write-one-to-clear strobes for the two interrupt factor flags. A frame that completes while the previous byte is still unacknowledged is an overrun. In that case the earlier byte stays in the buffer, the new byte is discarded, the error factor is raised and the receive-complete factor is left alone. Dropping the enable clears the three sticky error flags and idles the receiver.

Top module: `serial_rx_ack`

## Requirements
- R1: After reset, rx_data is 0 and err_par, err_ovr, err_frm, flag_rc, flag_err, irq_rc and irq_err are all 0.
- R2: While rx_en is 0, err_par, err_ovr and err_frm are held at 0 one cycle later. A frame sent on rxd while rx_en is 0 leaves rx_data and flag_rc unchanged.
- R3: A frame is a low start bit followed by DATA_W data bits sent least significant bit first, then one parity bit when par_en is 1, then a stop bit. Each bit lasts OVS pulses of bit_tick. rxd passes through a two-stage synchronizer, and a frame begins on a high-to-low change of the synchronized line.
- R4: If the line is high again when the start bit is re-sampled at its middle (OVS/2 ticks after the falling edge), the receiver returns to idle and sets no flag. A later valid frame is still received.
- R5: When a frame completes and the buffer is free, the data bits are written to rx_data, flag_rc is set and the buffer becomes owned by software until acknowledged.
- R6: A stop bit sampled low sets err_frm and flag_err. The data byte is still delivered as in R5 when the buffer is free.
- R7: With par_en at 1, the parity bit is checked when the byte is written to the buffer. With par_odd at 0, the data bits plus the parity bit must hold an even number of ones; with par_odd at 1 they must hold an odd number. A mismatch sets err_par and flag_err.
- R8: A frame that completes while the buffer is still owned by software (no rx_ack since the last load) sets err_ovr and flag_err. rx_data keeps the earlier byte, flag_rc is not set and no parity check is made.
- R9: An rx_ack pulse in the same cycle as frame completion frees the buffer for that frame, so the frame is loaded and no overrun is flagged.
- R10: clr_rc clears flag_rc and clr_err clears flag_err. If a setting event occurs in the same cycle as a clear strobe, the flag is set.
- R11: irq_rc is flag_rc gated by mask_rc, and irq_err is flag_err gated by mask_err. With a mask at 0, the request line stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-clock enable, OVS pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable level; low clears error flags |
| par_en | input | 1 | Expect and check a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rx_ack | input | 1 | Strobe: buffer has been read by software |
| clr_rc | input | 1 | Strobe: clear receive-complete factor flag |
| clr_err | input | 1 | Strobe: clear error factor flag |
| mask_rc | input | 1 | Receive-complete interrupt enable |
| mask_err | input | 1 | Error interrupt enable |
| rx_data | output | DATA_W | Receive data buffer |
| err_par | output | 1 | Sticky parity error flag |
| err_ovr | output | 1 | Sticky overrun error flag |
| err_frm | output | 1 | Sticky framing error flag |
| flag_rc | output | 1 | Receive-complete interrupt factor flag |
| flag_err | output | 1 | Error interrupt factor flag |
| irq_rc | output | 1 | Receive-complete interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The acknowledge strobe and the completion of a new frame can land in the same clock cycle. That is the point where a byte is either accepted or judged an overrun. The bench holds an unacknowledged byte and sends a second frame with the bit-clock phase fixed. It moves a single rx_ack pulse one cycle at a time across the stop bit. At every offset the result must be one of two clean outcomes: the new byte loaded with flag_rc set and no overrun, or the old byte kept with err_ovr set and flag_rc clear. Across the sweep the outcome must switch exactly once, from accepted to overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned RX_MAXW = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_t;

  // 1 when data ones plus the parity bit do not match the selected sense
  function automatic logic parity_bad(input logic [RX_MAXW-1:0] d,
                                      input logic pbit,
                                      input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  // tick count at which a bit is sampled, measured from the bit's start
  function automatic int unsigned mid_count(input int unsigned ovs);
    return (ovs / 2) - 1;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          sin,
  input  logic          par_en,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_pbit,
  output logic          frame_stop_ok
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(mid_count(OVS));
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  rx_state_t     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          sin_d;
  logic          pbit_q;
  logic          stop_q;
  logic          done_q;

  logic fall_seen;
  logic bit_due;
  logic start_due;

  assign fall_seen = sin_d && !sin;
  assign bit_due   = tick && (cnt == CNT_LAST);
  assign start_due = tick && (cnt == CNT_MID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      sin_d  <= 1'b1;
      pbit_q <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      sin_d  <= sin;
      done_q <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (fall_seen) state <= ST_START;
          end
          ST_START: begin
            if (start_due) begin
              cnt <= '0;
              if (!sin) begin
                state <= ST_DATA;
                bitn  <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_due) begin
              cnt   <= '0;
              shreg <= {sin, shreg[DW-1:1]};
              if (bitn == BIT_LAST) state <= par_en ? ST_PAR : ST_STOP;
              else                  bitn  <= bitn + 1'b1;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_due) begin
              cnt    <= '0;
              pbit_q <= sin;
              state  <= ST_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_due) begin
              cnt    <= '0;
              stop_q <= sin;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign frame_done    = done_q;
  assign frame_data    = shreg;
  assign frame_pbit    = pbit_q;
  assign frame_stop_ok = stop_q;
endmodule

// File: rtl/rx_status.sv
module rx_status
  import serial_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_pbit,
  input  logic          frame_stop_ok,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          ack,
  input  logic          clr_rc,
  input  logic          clr_err,
  output logic [DW-1:0] rx_data,
  output logic          err_par,
  output logic          err_ovr,
  output logic          err_frm,
  output logic          flag_rc,
  output logic          flag_err,
  output logic          buf_full
);
  logic buf_free;
  logic evt_load;
  logic evt_ovr;
  logic evt_perr;
  logic evt_ferr;
  logic evt_any_err;

  assign buf_free    = !buf_full || ack;
  assign evt_load    = frame_done && buf_free;
  assign evt_ovr     = frame_done && !buf_free;
  assign evt_perr    = evt_load && par_en &&
                       parity_bad(RX_MAXW'(frame_data), frame_pbit, par_odd);
  assign evt_ferr    = frame_done && !frame_stop_ok;
  assign evt_any_err = evt_ovr || evt_perr || evt_ferr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      err_par  <= 1'b0;
      err_ovr  <= 1'b0;
      err_frm  <= 1'b0;
      flag_rc  <= 1'b0;
      flag_err <= 1'b0;
    end else begin
      if (evt_load) rx_data <= frame_data;

      if (evt_load) buf_full <= 1'b1;
      else if (ack) buf_full <= 1'b0;

      if (!en) begin
        err_par <= 1'b0;
        err_ovr <= 1'b0;
        err_frm <= 1'b0;
      end else begin
        if (evt_perr) err_par <= 1'b1;
        if (evt_ovr)  err_ovr <= 1'b1;
        if (evt_ferr) err_frm <= 1'b1;
      end

      if (evt_load)    flag_rc <= 1'b1;
      else if (clr_rc) flag_rc <= 1'b0;

      if (evt_any_err)  flag_err <= 1'b1;
      else if (clr_err) flag_err <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_ack.sv
module serial_rx_ack #(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_ack,
  input  logic              clr_rc,
  input  logic              clr_err,
  input  logic              mask_rc,
  input  logic              mask_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_par,
  output logic              err_ovr,
  output logic              err_frm,
  output logic              flag_rc,
  output logic              flag_err,
  output logic              irq_rc,
  output logic              irq_err
);
  logic              sin_sync;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_pbit;
  logic              frame_stop_ok;
  logic              buf_full;

  rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (sin_sync)
  );

  rx_framer #(.OVS(OVS), .DW(DATA_W)) u_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (rx_en),
    .tick         (bit_tick),
    .sin          (sin_sync),
    .par_en       (par_en),
    .frame_done   (frame_done),
    .frame_data   (frame_data),
    .frame_pbit   (frame_pbit),
    .frame_stop_ok(frame_stop_ok)
  );

  rx_status #(.DW(DATA_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (rx_en),
    .frame_done   (frame_done),
    .frame_data   (frame_data),
    .frame_pbit   (frame_pbit),
    .frame_stop_ok(frame_stop_ok),
    .par_en       (par_en),
    .par_odd      (par_odd),
    .ack          (rx_ack),
    .clr_rc       (clr_rc),
    .clr_err      (clr_err),
    .rx_data      (rx_data),
    .err_par      (err_par),
    .err_ovr      (err_ovr),
    .err_frm      (err_frm),
    .flag_rc      (flag_rc),
    .flag_err     (flag_err),
    .buf_full     (buf_full)
  );

  assign irq_rc  = flag_rc && mask_rc;
  assign irq_err = flag_err && mask_err;
endmodule

// File: rtl/serial_rx_ack_chk.sv
module serial_rx_ack_chk
  import serial_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          par_en,
  input logic          par_odd,
  input logic          rx_ack,
  input logic          mask_rc,
  input logic          mask_err,
  input logic          frame_done,
  input logic [DW-1:0] frame_data,
  input logic          frame_pbit,
  input logic          frame_stop_ok,
  input logic          buf_full,
  input logic [DW-1:0] rx_data,
  input logic          err_par,
  input logic          err_ovr,
  input logic          err_frm,
  input logic          flag_rc,
  input logic          flag_err,
  input logic          irq_rc,
  input logic          irq_err
);
  p_disabled_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!err_par && !err_ovr && !err_frm));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (!buf_full || rx_ack)) |=>
      (flag_rc && buf_full && (rx_data == $past(frame_data))));

  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_en && !frame_stop_ok) |=> (err_frm && flag_err));

  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_en && (!buf_full || rx_ack) && par_en &&
     parity_bad(RX_MAXW'(frame_data), frame_pbit, par_odd)) |=> (err_par && flag_err));

  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_en && buf_full && !rx_ack) |=>
      (err_ovr && flag_err && $stable(rx_data)));

  p_mask_rc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_rc |-> !irq_rc);

  p_mask_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_err |-> !irq_err);
endmodule

bind serial_rx_ack serial_rx_ack_chk #(.DW(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .par_en       (par_en),
  .par_odd      (par_odd),
  .rx_ack       (rx_ack),
  .mask_rc      (mask_rc),
  .mask_err     (mask_err),
  .frame_done   (frame_done),
  .frame_data   (frame_data),
  .frame_pbit   (frame_pbit),
  .frame_stop_ok(frame_stop_ok),
  .buf_full     (buf_full),
  .rx_data      (rx_data),
  .err_par      (err_par),
  .err_ovr      (err_ovr),
  .err_frm      (err_frm),
  .flag_rc      (flag_rc),
  .flag_err     (flag_err),
  .irq_rc       (irq_rc),
  .irq_err      (irq_err)
);

// File: tb/tb_serial_rx_ack.sv
`timescale 1ns/1ps
module tb_serial_rx_ack;
  localparam int OVS = 16;
  localparam int TD  = 2;
  localparam int BIT = OVS * TD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick;
  logic       rxd = 1'b1;
  logic       rx_en = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rx_ack = 1'b0;
  logic       clr_rc = 1'b0;
  logic       clr_err = 1'b0;
  logic       mask_rc = 1'b0;
  logic       mask_err = 1'b0;
  logic [7:0] rx_data;
  logic       err_par, err_ovr, err_frm, flag_rc, flag_err, irq_rc, irq_err;

  int n_run = 0;
  int n_fail = 0;
  int tdiv;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv     <= 0;
      bit_tick <= 1'b0;
    end else begin
      tdiv     <= (tdiv == TD - 1) ? 0 : tdiv + 1;
      bit_tick <= (tdiv == TD - 1);
    end
  end

  serial_rx_ack #(.OVS(OVS), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rxd(rxd),
    .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .rx_ack(rx_ack),
    .clr_rc(clr_rc), .clr_err(clr_err), .mask_rc(mask_rc), .mask_err(mask_err),
    .rx_data(rx_data), .err_par(err_par), .err_ovr(err_ovr), .err_frm(err_frm),
    .flag_rc(flag_rc), .flag_err(flag_err), .irq_rc(irq_rc), .irq_err(irq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic want_pbit(input logic [7:0] d, input logic odd);
    logic ones_odd;
    ones_odd = ($countones(d) % 2) == 1;
    return odd ? !ones_odd : ones_odd;
  endfunction

  task automatic hold_line(input logic v, input int cycles);
    rxd = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input logic stop_v);
    hold_line(1'b0, BIT);
    for (int i = 0; i < 8; i++) hold_line(d[i], BIT);
    if (par_en) hold_line(want_pbit(d, par_odd) ^ flip_par, BIT);
    hold_line(stop_v, BIT);
    hold_line(1'b1, BIT);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    @(negedge clk);
  endtask

  task automatic clean();
    rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rx_en = 1'b1;
    pulse(rx_ack);
    pulse(clr_rc);
    pulse(clr_err);
  endtask

  task automatic t_reset();
    chk("R1 rx_data", rx_data, 0);
    chk("R1 errors", {err_par, err_ovr, err_frm}, 0);
    chk("R1 flags", {flag_rc, flag_err}, 0);
    chk("R1 irqs", {irq_rc, irq_err}, 0);
  endtask

  task automatic t_basic();
    clean();
    mask_rc = 1'b1;
    send_frame(8'hA5, 0, 1'b1);
    chk("R3 R5 data A5", rx_data, 8'hA5);
    chk("R5 flag_rc", flag_rc, 1);
    chk("R11 irq_rc masked on", irq_rc, 1);
    chk("R5 no errors", {err_par, err_ovr, err_frm, flag_err}, 0);
    pulse(rx_ack);
    pulse(clr_rc);
    chk("R10 clr_rc", flag_rc, 0);
    send_frame(8'h3C, 0, 1'b1);
    chk("R3 R5 data 3C", rx_data, 8'h3C);
    chk("R5 flag_rc second", flag_rc, 1);
    mask_rc = 1'b0;
    @(negedge clk);
    chk("R11 irq_rc masked off", irq_rc, 0);
  endtask

  task automatic t_framing();
    clean();
    mask_err = 1'b1;
    send_frame(8'h81, 0, 1'b0);
    chk("R6 err_frm", err_frm, 1);
    chk("R6 flag_err", flag_err, 1);
    chk("R11 irq_err", irq_err, 1);
    chk("R6 data delivered", rx_data, 8'h81);
    pulse(clr_err);
    chk("R10 clr_err", flag_err, 0);
    chk("R6 err_frm sticky", err_frm, 1);
    mask_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_parity();
    clean();
    par_en = 1'b1;
    par_odd = 1'b0;
    send_frame(8'h37, 0, 1'b1);
    chk("R7 even good data", rx_data, 8'h37);
    chk("R7 even good no err", {err_par, flag_err}, 0);
    pulse(rx_ack);
    send_frame(8'h37, 1, 1'b1);
    chk("R7 even bad err_par", {err_par, flag_err}, 2'b11);
    clean();
    par_odd = 1'b1;
    send_frame(8'hF0, 0, 1'b1);
    chk("R7 odd good", {err_par, flag_err, flag_rc}, 3'b001);
    pulse(rx_ack);
    send_frame(8'hF1, 1, 1'b1);
    chk("R7 odd bad", {err_par, flag_err}, 2'b11);
    par_en = 1'b0;
    par_odd = 1'b0;
  endtask

  task automatic t_overrun();
    clean();
    send_frame(8'h11, 0, 1'b1);
    pulse(clr_rc);
    send_frame(8'h22, 0, 1'b1);
    chk("R8 err_ovr", err_ovr, 1);
    chk("R8 flag_err", flag_err, 1);
    chk("R8 data kept", rx_data, 8'h11);
    chk("R8 flag_rc not set", flag_rc, 0);
  endtask

  task automatic t_disable();
    chk("R2 precondition ovr", err_ovr, 1);
    rx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 errors cleared", {err_par, err_ovr, err_frm}, 0);
    pulse(rx_ack);
    pulse(clr_rc);
    send_frame(8'h99, 0, 1'b1);
    chk("R2 ignored flag_rc", flag_rc, 0);
    chk("R2 ignored data", rx_data, 8'h11);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_glitch();
    clean();
    hold_line(1'b0, 3);
    hold_line(1'b1, 2 * BIT);
    chk("R4 glitch no rc", flag_rc, 0);
    chk("R4 glitch no err", {err_par, err_ovr, err_frm, flag_err}, 0);
    send_frame(8'h6E, 0, 1'b1);
    chk("R4 after glitch data", rx_data, 8'h6E);
  endtask

  task automatic prime_full(input logic [7:0] a);
    clean();
    send_frame(a, 0, 1'b1);
    pulse(clr_rc);
  endtask

  task automatic t_ack_race();
    int switches = 0;
    int prev = 1;
    int first = -1;
    int last = -1;
    for (int k = 0; k <= 40; k++) begin
      int outcome;
      prime_full(8'h5A);
      while (tdiv != 0) @(negedge clk);
      fork
        send_frame(8'hC3, 0, 1'b1);
        begin
          repeat (9 * BIT + k) @(negedge clk);
          rx_ack = 1'b1;
          @(negedge clk);
          rx_ack = 1'b0;
        end
      join
      if (rx_data == 8'hC3 && !err_ovr && flag_rc) outcome = 1;
      else if (rx_data == 8'h5A && err_ovr && !flag_rc) outcome = 0;
      else outcome = 2;
      chk("R9 clean outcome", (outcome == 2) ? 1 : 0, 0);
      if (k == 0) first = outcome;
      last = outcome;
      if (outcome != prev) switches++;
      prev = outcome;
    end
    chk("R9 early ack accepted", first, 1);
    chk("R9 late ack overrun", last, 0);
    chk("R9 single switch", switches, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_framing();
    t_parity();
    t_overrun();
    t_disable();
    t_glitch();
    t_ack_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule